// File: doc/BRIEF.md
# Minimal Multi-Cycle RISC Core

A 32-bit little-endian processor core that runs one instruction at a time. It fetches an instruction word, decodes and executes it, and for loads adds a third cycle to write back the returned data. Register 0 is the program counter, but it is otherwise an ordinary register. The sequencer moves it forward by four during fetch, so any instruction that reads it sees the address of the next instruction. There is no jump opcode: an instruction that writes register 0 takes a branch.

The core has a single byte-addressed memory port. Read data comes back one cycle after the address is presented. A write is carried out in the cycle in which the write strobe is high, with byte enables that select the lanes. Instruction fetch, data loads and data stores all share this port.

Top module: `rcore`

## Requirements
- R1: After reset every register holds zero, the first fetch is from address 0, and the write strobe is low.
- R2: Each instruction spends one fetch cycle and one execute cycle. A load adds one write-back cycle. The fetch address is register 0, which has already been raised by 4 when the instruction executes, so reading register 0 gives the instruction's own address plus 4.
- R3: An instruction that writes register 0 moves execution to the written value, and that value replaces the automatic advance. A relative branch adds to register 0.
- R4: The instruction word holds the opcode in bits 7:0, destination A in bits 15:8, first source B in bits 23:16 and second source C in bits 31:24. A register field selects register (field mod 32).
- R5: add (0x01) and sub (0x02) compute B+C and B−C modulo 2^32. and (0x03), orr (0x04) and xor (0x05) are bitwise on B and C. not (0x06) inverts B. All of them write the result to A.
- R6: lsh (0x07) and ash (0x08) shift B by the signed count in C. A positive count shifts left and fills with zeros. A negative count shifts right by its magnitude, filling with zeros for lsh and with copies of bit 31 for ash.
- R7: tcu (0x09) and tcs (0x0a) write 1 to A when B is less than C, compared unsigned and signed respectively, and write 0 otherwise.
- R8: set (0x0b) writes bits 31:16 of the instruction, sign-extended to 32 bits, into A. mov (0x0c) copies B into A.
- R9: ldw (0x0d) reads the word at the address in B, with address bits 1:0 cleared, into A.
- R10: stw (0x0e) drives one write cycle of B's value to the address in A with bits 1:0 cleared, with all four byte enables set.
- R11: ldb (0x0f) takes byte lane (B mod 4) of the word returned for the address in B and puts it in bits 7:0 of A. Bits 31:8 of A are kept.
- R12: stb (0x10) drives one write cycle to the unmodified address in A. Only enable bit (address mod 4) is set, and the write data repeats B[7:0] in all four lanes.
- R13: nop (0x00) and every opcode above 0x10 change no register except the normal advance of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for fetch, load or store |
| mem_wdata | output | 32 | Store data |
| mem_be | output | 4 | Byte enables for a store, bit n for lane n |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 32 | Word at the address of the previous cycle |

## Verification
A corrupted register or a wrong sequencer state becomes visible at the memory port within a few cycles. A bad program counter shows up as a wrong fetch address in the next fetch cycle, and it then shifts the cycle at which every later store appears. The test program therefore stores each result to memory, and the bench checks the data, address, byte enables and the exact cycle of every write. A missed or extra write-back cycle shifts all later stores by one cycle. A lost branch or a wrongly executed undefined opcode changes a stored value in the next store.

// File: rtl/rcore_pkg.sv
`timescale 1ns/1ps
package rcore_pkg;
  parameter int unsigned XLEN = 32;
  localparam int unsigned NBYTE = XLEN / 8;
  localparam int unsigned LANEW = $clog2(NBYTE);
  localparam int unsigned SHW   = $clog2(XLEN);
  localparam int unsigned FLDW  = 8;
  localparam int unsigned IMMW  = 16;

  typedef enum logic [FLDW-1:0] {
    OP_NOP = 8'h00, OP_ADD = 8'h01, OP_SUB = 8'h02, OP_AND = 8'h03,
    OP_ORR = 8'h04, OP_XOR = 8'h05, OP_NOT = 8'h06, OP_LSH = 8'h07,
    OP_ASH = 8'h08, OP_TCU = 8'h09, OP_TCS = 8'h0a, OP_SET = 8'h0b,
    OP_MOV = 8'h0c, OP_LDW = 8'h0d, OP_STW = 8'h0e, OP_LDB = 8'h0f,
    OP_STB = 8'h10
  } opcode_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_MEM} state_e;

  // Signed-count shift: positive left, negative right by magnitude.
  function automatic logic [XLEN-1:0] shift_by(input logic [XLEN-1:0] v,
                                               input logic [XLEN-1:0] amt,
                                               input logic arith);
    logic [XLEN-1:0] mag;
    logic [SHW-1:0]  n;
    mag = amt[XLEN-1] ? (~amt + 1'b1) : amt;
    n   = SHW'(mag % XLEN);
    if (!amt[XLEN-1]) return v << n;
    else if (arith)   return XLEN'($signed(v) >>> n);
    else              return v >> n;
  endfunction

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] imm);
    return {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  endfunction

  function automatic logic [7:0] byte_pick(input logic [XLEN-1:0] w,
                                           input logic [LANEW-1:0] lane);
    logic [XLEN-1:0] s;
    s = w >> (8 * lane);
    return s[7:0];
  endfunction

  function automatic logic [NBYTE-1:0] lane_mask(input logic [LANEW-1:0] lane);
    logic [NBYTE-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rcore_decode.sv
`timescale 1ns/1ps
module rcore_decode import rcore_pkg::*; #(
  parameter int unsigned NREG = 32,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic [XLEN-1:0] instr,
  output opcode_e         op,
  output logic [IDXW-1:0] idx_a,
  output logic [IDXW-1:0] idx_b,
  output logic [IDXW-1:0] idx_c,
  output logic [IMMW-1:0] imm,
  output logic            alu_wr,
  output logic            is_ld,
  output logic            is_st,
  output logic            is_byte
);
  assign op    = opcode_e'(instr[FLDW-1:0]);
  assign idx_a = IDXW'(instr[2*FLDW-1:FLDW] % NREG);
  assign idx_b = IDXW'(instr[3*FLDW-1:2*FLDW] % NREG);
  assign idx_c = IDXW'(instr[4*FLDW-1:3*FLDW] % NREG);
  assign imm   = instr[XLEN-1:XLEN-IMMW];

  always_comb begin
    alu_wr = 1'b0;
    is_ld  = 1'b0;
    is_st  = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_ORR, OP_XOR, OP_NOT, OP_LSH,
      OP_ASH, OP_TCU, OP_TCS, OP_SET, OP_MOV: alu_wr = 1'b1;
      OP_LDW, OP_LDB: is_ld = 1'b1;
      OP_STW, OP_STB: is_st = 1'b1;
      default: ;
    endcase
  end
  assign is_byte = (op == OP_LDB) || (op == OP_STB);
endmodule

// File: rtl/rcore_alu.sv
`timescale 1ns/1ps
module rcore_alu import rcore_pkg::*; (
  input  opcode_e         op,
  input  logic [XLEN-1:0] src_b,
  input  logic [XLEN-1:0] src_c,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = src_b + src_c;
      OP_SUB:  res = src_b - src_c;
      OP_AND:  res = src_b & src_c;
      OP_ORR:  res = src_b | src_c;
      OP_XOR:  res = src_b ^ src_c;
      OP_NOT:  res = ~src_b;
      OP_LSH:  res = shift_by(src_b, src_c, 1'b0);
      OP_ASH:  res = shift_by(src_b, src_c, 1'b1);
      OP_TCU:  res = {{(XLEN-1){1'b0}}, (src_b < src_c)};
      OP_TCS:  res = {{(XLEN-1){1'b0}}, ($signed(src_b) < $signed(src_c))};
      OP_SET:  res = sext_imm(imm);
      OP_MOV:  res = src_b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
`timescale 1ns/1ps
module rcore_regfile import rcore_pkg::*; #(
  parameter int unsigned NREG = 32,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra,
  input  logic [IDXW-1:0] rb,
  input  logic [IDXW-1:0] rc,
  input  logic            we,
  input  logic [IDXW-1:0] wa,
  input  logic [XLEN-1:0] wd,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_c,
  output logic [XLEN-1:0] pc
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[wa] <= wd;
    end
  end

  assign rd_a = regs_q[ra];
  assign rd_b = regs_q[rb];
  assign rd_c = regs_q[rc];
  assign pc   = regs_q[0];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs_q[$past(wa)] == $past(wd)); // R4
endmodule

// File: rtl/rcore.sv
`timescale 1ns/1ps
module rcore import rcore_pkg::*; #(
  parameter int unsigned NREG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [NBYTE-1:0] mem_be,
  output logic             mem_we,
  input  logic [XLEN-1:0]  mem_rdata
);
  localparam int unsigned IDXW = $clog2(NREG);

  state_e          state_q;
  logic [XLEN-1:0] ir_q;
  logic [LANEW-1:0] lane_q;
  logic [XLEN-1:0] instr;

  opcode_e         op;
  logic [IDXW-1:0] idx_a, idx_b, idx_c;
  logic [IMMW-1:0] imm;
  logic            alu_wr, is_ld, is_st, is_byte;
  logic [XLEN-1:0] rd_a, rd_b, rd_c, pc, alu_res;
  logic            rf_we;
  logic [IDXW-1:0] rf_wa;
  logic [XLEN-1:0] rf_wd;
  logic [XLEN-1:0] ld_addr, st_addr;

  // Named internal events
  logic fetch_evt, exec_evt, load_evt, store_evt, fill_evt;
  assign fetch_evt = (state_q == ST_FETCH);
  assign exec_evt  = (state_q == ST_EXEC);
  assign fill_evt  = (state_q == ST_MEM);
  assign load_evt  = exec_evt && is_ld;
  assign store_evt = exec_evt && is_st;

  assign instr = exec_evt ? mem_rdata : ir_q;

  rcore_decode #(.NREG(NREG)) u_dec (
    .instr(instr), .op(op), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .imm(imm), .alu_wr(alu_wr), .is_ld(is_ld), .is_st(is_st), .is_byte(is_byte)
  );

  rcore_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra(idx_a), .rb(idx_b), .rc(idx_c),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .rd_a(rd_a), .rd_b(rd_b), .rd_c(rd_c), .pc(pc)
  );

  rcore_alu u_alu (
    .op(op), .src_b(rd_b), .src_c(rd_c), .imm(imm), .res(alu_res)
  );

  assign ld_addr = is_byte ? rd_b : {rd_b[XLEN-1:LANEW], {LANEW{1'b0}}};
  assign st_addr = is_byte ? rd_a : {rd_a[XLEN-1:LANEW], {LANEW{1'b0}}};

  // Register write port: pc advance, ALU result, or load fill
  always_comb begin
    rf_we = 1'b0;
    rf_wa = idx_a;
    rf_wd = alu_res;
    unique case (state_q)
      ST_FETCH: begin
        rf_we = 1'b1;
        rf_wa = '0;
        rf_wd = pc + XLEN'(NBYTE);
      end
      ST_EXEC: rf_we = alu_wr;
      ST_MEM: begin
        rf_we = 1'b1;
        rf_wd = is_byte ? {rd_a[XLEN-1:8], byte_pick(mem_rdata, lane_q)}
                        : mem_rdata;
      end
      default: ;
    endcase
  end

  // Memory port
  always_comb begin
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_wdata = '0;
    if (load_evt) mem_addr = ld_addr;
    if (store_evt) begin
      mem_addr  = st_addr;
      mem_we    = 1'b1;
      mem_be    = is_byte ? lane_mask(st_addr[LANEW-1:0]) : '1;
      mem_wdata = is_byte ? {NBYTE{rd_b[7:0]}} : rd_b;
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_EXEC;
        ST_EXEC: begin
          ir_q    <= mem_rdata;
          lane_q  <= ld_addr[LANEW-1:0];
          state_q <= is_ld ? ST_MEM : ST_FETCH;
        end
        ST_MEM:  state_q <= ST_FETCH;
        default: state_q <= ST_FETCH;
      endcase
    end
  end

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_evt |=> pc == $past(pc) + XLEN'(NBYTE)); // R2
  AST_EXEC_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    exec_evt |=> !exec_evt); // R2
  AST_WRITE_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_evt || fill_evt) |-> !mem_we); // R2
  AST_FILL_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> $past(load_evt)); // R9
  AST_WORD_LOAD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !is_byte) |-> mem_addr[LANEW-1:0] == '0); // R9
  AST_STORE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_be == '1 && mem_addr[LANEW-1:0] == '0) ||
                ($countones(mem_be) == 1 && mem_be[mem_addr[LANEW-1:0]]))); // R12
endmodule

// File: tb/rcore_tb.sv
`timescale 1ns/1ps
module rcore_tb;
  localparam logic [7:0] C_NOP = 8'h00, C_ADD = 8'h01, C_SUB = 8'h02,
    C_AND = 8'h03, C_ORR = 8'h04, C_XOR = 8'h05, C_NOT = 8'h06,
    C_LSH = 8'h07, C_ASH = 8'h08, C_TCU = 8'h09, C_TCS = 8'h0a,
    C_SET = 8'h0b, C_MOV = 8'h0c, C_LDW = 8'h0d, C_STW = 8'h0e,
    C_LDB = 8'h0f, C_STB = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        mem_we;

  always #4 clk = ~clk;

  rcore u_dut (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we),
    .mem_rdata(mem_rdata));

  logic [31:0] img [256];
  logic [31:0] mem [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] <= img[k];
      mem_rdata <= '0;
    end else begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (mem_we)
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem[mem_addr[9:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    int          cyc;
    string       tag;
  } exp_t;
  exp_t expq[$];
  exp_t cur;

  int n_chk = 0, n_err = 0;
  int pc_w = 0, ecyc = 0;
  logic [31:0] ptr;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [7:0] op, input logic [7:0] a,
                                      input logic [7:0] b, input logic [7:0] c);
    return {c, b, a, op};
  endfunction
  function automatic logic [31:0] enc_set(input logic [7:0] a, input logic [15:0] v);
    return {v, a, C_SET};
  endfunction

  task automatic put(input logic [31:0] w);
    img[pc_w] = w; pc_w++; ecyc += 2;
  endtask
  task automatic put_ld(input logic [31:0] w);
    img[pc_w] = w; pc_w++; ecyc += 3;
  endtask
  task automatic want(input logic [31:0] a, input logic [31:0] d,
                      input logic [3:0] be, input string tag);
    exp_t e;
    e.addr = a; e.data = d; e.be = be; e.cyc = ecyc + 1; e.tag = tag;
    expq.push_back(e);
  endtask
  task automatic chk(input logic [7:0] r, input logic [31:0] v, input string tag);
    want(ptr, v, 4'hF, tag);
    put(enc(C_STW, 8'd1, r, 8'd0));
    put(enc(C_ADD, 8'd1, 8'd1, 8'd2));
    ptr += 4;
  endtask

  // Monitor: pop expected stores as the core produces them
  always @(negedge clk) begin
    if (rst_n === 1'b1 && mem_we === 1'b1) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2", "unexpected store", mem_addr, 32'h0);
      end else begin
        cur = expq.pop_front();
        check(mem_addr === cur.addr, cur.tag, "store address", mem_addr, cur.addr);
        check(mem_wdata === cur.data, cur.tag, "store data", mem_wdata, cur.data);
        check(mem_be === cur.be, cur.tag, "byte enables", {28'h0, mem_be}, {28'h0, cur.be});
        check(cyc == cur.cyc, "R2", "store cycle", cyc, cur.cyc);
      end
    end
  end

  initial begin
    logic [31:0] p;
    for (int k = 0; k < 256; k++) img[k] = 32'h0;
    img[32'h300 >> 2] = 32'hA1B2C3D4;
    ptr = 32'h340;

    // R1: registers clear, store zero to address zero
    want(32'h0, 32'h0, 4'hF, "R1");
    put(enc(C_STW, 8'd10, 8'd9, 8'd0));
    put(enc_set(8'd1, 16'h0340));
    put(enc_set(8'd2, 16'h0004));
    put(enc_set(8'd3, 16'h1234));
    put(enc_set(8'd4, 16'hFFFD));
    // R5
    put(enc(C_ADD, 5, 3, 4)); chk(5, 32'h1234 + 32'hFFFFFFFD, "R5");
    put(enc(C_SUB, 5, 3, 4)); chk(5, 32'h1234 - 32'hFFFFFFFD, "R5");
    put(enc(C_AND, 5, 3, 4)); chk(5, 32'h1234 & 32'hFFFFFFFD, "R5");
    put(enc(C_ORR, 5, 3, 4)); chk(5, 32'h1234 | 32'hFFFFFFFD, "R5");
    put(enc(C_XOR, 5, 3, 4)); chk(5, 32'h1234 ^ 32'hFFFFFFFD, "R5");
    put(enc(C_NOT, 5, 3, 0)); chk(5, ~32'h1234, "R5");
    // R6
    put(enc_set(8'd6, 16'h0004));
    put(enc(C_LSH, 5, 3, 6)); chk(5, 32'h1234 << 4, "R6");
    put(enc(C_ASH, 5, 4, 6)); chk(5, 32'hFFFFFFFD << 4, "R6");
    put(enc_set(8'd6, 16'hFFFC));
    put(enc(C_LSH, 5, 3, 6)); chk(5, 32'h1234 >> 4, "R6");
    put(enc(C_LSH, 5, 4, 6)); chk(5, 32'hFFFFFFFD >> 4, "R6");
    put(enc(C_ASH, 5, 4, 6)); chk(5, 32'hFFFFFFFF, "R6");
    // R7
    put(enc(C_TCU, 5, 3, 4)); chk(5, 32'd1, "R7");
    put(enc(C_TCU, 5, 4, 3)); chk(5, 32'd0, "R7");
    put(enc(C_TCS, 5, 3, 4)); chk(5, 32'd0, "R7");
    put(enc(C_TCS, 5, 4, 3)); chk(5, 32'd1, "R7");
    // R8
    put(enc_set(8'd5, 16'h8000)); chk(5, 32'hFFFF8000, "R8");
    put(enc_set(8'd5, 16'h7FFF)); chk(5, 32'h00007FFF, "R8");
    put(enc(C_MOV, 5, 3, 0)); chk(5, 32'h1234, "R8");
    // R4: field bits above the register count are dropped
    put(enc(C_ADD, 8'h25, 8'h23, 8'h24)); chk(5, 32'h1231, "R4");
    // R2: reading register 0
    p = pc_w * 4;
    put(enc(C_MOV, 5, 0, 0)); chk(5, p + 4, "R2");
    // R3: absolute branch over two poison words
    put(enc_set(8'd5, 16'h0077));
    p = pc_w * 4;
    put(enc_set(8'd0, 16'(p + 12)));
    img[pc_w] = enc_set(8'd5, 16'h0BAD); img[pc_w + 1] = enc_set(8'd5, 16'h0BAD);
    pc_w += 2;
    chk(5, 32'h77, "R3");
    // R3: relative branch over one poison word
    put(enc(C_ADD, 0, 0, 2));
    img[pc_w] = enc_set(8'd5, 16'h0BAD); pc_w++;
    chk(5, 32'h77, "R3");
    // R13
    put(enc_set(8'd5, 16'h0055));
    put(enc(8'h3F, 5, 3, 4));
    put(enc(8'hFF, 5, 3, 4));
    put(enc(C_NOP, 5, 3, 4));
    chk(5, 32'h55, "R13");
    // R9
    put(enc_set(8'd8, 16'h0300)); put_ld(enc(C_LDW, 5, 8, 0)); chk(5, 32'hA1B2C3D4, "R9");
    put(enc_set(8'd8, 16'h0302)); put_ld(enc(C_LDW, 5, 8, 0)); chk(5, 32'hA1B2C3D4, "R9");
    // R11
    put(enc(C_MOV, 5, 3, 0));
    put(enc_set(8'd8, 16'h0302)); put_ld(enc(C_LDB, 5, 8, 0)); chk(5, 32'h000012B2, "R11");
    put(enc_set(8'd8, 16'h0301)); put_ld(enc(C_LDB, 5, 8, 0)); chk(5, 32'h000012C3, "R11");
    // R12
    put(enc_set(8'd8, 16'h0311));
    want(32'h311, 32'h34343434, 4'b0010, "R12"); put(enc(C_STB, 8, 3, 0));
    put(enc_set(8'd8, 16'h0313));
    want(32'h313, 32'hFDFDFDFD, 4'b1000, "R12"); put(enc(C_STB, 8, 4, 0));
    put(enc_set(8'd8, 16'h0310)); put_ld(enc(C_LDW, 5, 8, 0)); chk(5, 32'hFD003400, "R12");
    // R10: misaligned word store drops address bits 1:0
    put(enc_set(8'd8, 16'h0316));
    want(32'h314, 32'hFFFFFFFD, 4'hF, "R10"); put(enc(C_STW, 8, 4, 0));
    // park: branch to self
    p = pc_w * 4;
    put(enc_set(8'd0, 16'(p)));

    // Reset state (R1)
    repeat (3) @(negedge clk);
    check(mem_we === 1'b0, "R1", "write strobe in reset", {31'h0, mem_we}, 32'h0);
    check(mem_addr === 32'h0, "R1", "address in reset", mem_addr, 32'h0);
    rst_n = 1'b1;
    check(mem_addr === 32'h0, "R1", "first fetch address", mem_addr, 32'h0);

    begin
      int unsigned wd = 0;
      while (expq.size() != 0 && wd < 5000) begin
        @(negedge clk);
        wd++;
      end
      if (expq.size() != 0)
        check(1'b0, "R2", "watchdog expired, stores pending", expq.size(), 32'h0);
    end
    repeat (30) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule